// File: doc/BRIEF.md
# Conversion Result Readout Lock

This block sits between a converter and a byte-wide register bus. It keeps the latest 10-bit conversion result and shows it as two 8-bit bytes, a low byte and a high byte. A select input places the result either at the bottom of the 16-bit pair (right adjusted) or at the top (left adjusted). The byte views follow the select at once, with no new conversion needed.

Software reads a full-precision result low byte first. That read engages a lock, and the lock freezes both bytes until the high byte is read. A conversion that finishes while the lock is held is thrown away, so the two bytes always come from the same conversion. The completion flag pulse is still raised for that lost conversion.

In left-adjust mode, software that needs only 8 bits reads the high byte alone. That read never engages the lock.

Top module: `result_readout_lock`

## Requirements
- R1: After reset both bytes read 0x00, `flag_set_o` is low, and the lock is released, so the first completion updates the bytes.
- R2: With `left_adj_i` = 0, `hi_byte_o` = {6'b0, result[9:8]} and `lo_byte_o` = result[7:0].
- R3: With `left_adj_i` = 1, `hi_byte_o` = result[9:2] and `lo_byte_o` = {result[1:0], 6'b0}.
- R4: A `conv_done_i` pulse with the lock released stores `conv_result_i`. The bytes show the new value from the next clock cycle.
- R5: A cycle with `rd_lo_i` high engages the lock. While the lock is held, a completion changes neither byte.
- R6: A cycle with `rd_hi_i` high releases the lock. The next completion updates the bytes again.
- R7: `flag_set_o` is high for exactly the one cycle after each `conv_done_i` cycle, whether the result was stored or discarded.
- R8: Reading only the high byte, in either adjust mode, leaves the lock released.
- R9: A change of `left_adj_i` reformats the held result in the same cycle, with no clock edge and no new conversion.
- R10: A completion in the same cycle as a low-byte read is discarded. When `rd_lo_i` and `rd_hi_i` are high in the same cycle, the lock ends released.
- R11: A completion in the same cycle as the high-byte read that releases a held lock is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| conv_result_i | input | 10 | Result from the converter |
| conv_done_i | input | 1 | One-cycle completion strobe |
| left_adj_i | input | 1 | 1 = left-adjusted placement, 0 = right-adjusted |
| rd_lo_i | input | 1 | Bus read strobe for the low byte |
| rd_hi_i | input | 1 | Bus read strobe for the high byte |
| lo_byte_o | output | 8 | Low byte view of the held result |
| hi_byte_o | output | 8 | High byte view of the held result |
| flag_set_o | output | 1 | One-cycle pulse that sets the completion interrupt flag |

## Verification
A lock that sticks after a high-byte read shows up on the next completion: the bytes stay at the old value one cycle after that completion, when they should have changed. A lock that never engages shows the opposite: new data appears one cycle after a completion that follows a low-byte read. A wrong placement or a stale format shows at once, in the same cycle as a change of the adjust select. A lost or doubled flag pulse shows one cycle after the completion strobe.

// File: rtl/rrl_pkg.sv
package rrl_pkg;
    typedef enum logic {
        ADJ_RIGHT = 1'b0,
        ADJ_LEFT  = 1'b1
    } adj_e;

    typedef enum logic {
        LK_OPEN = 1'b0,
        LK_HELD = 1'b1
    } lock_e;
endpackage

// File: rtl/rrl_lock_ctl.sv
module rrl_lock_ctl
    import rrl_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_lo_i,
    input  logic rd_hi_i,
    output logic blocked_o
);
    typedef struct packed {
        lock_e lock;
    } lk_state_t;

    lk_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (rd_hi_i) begin
            st_d.lock = LK_OPEN;
        end else if (rd_lo_i) begin
            st_d.lock = LK_HELD;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{lock: LK_OPEN};
        end else begin
            st_q <= st_d;
        end
    end

    // A low read blocks its own cycle; a held lock blocks until released
    assign blocked_o = (st_q.lock == LK_HELD) || rd_lo_i;

    assert_lock_engage_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lo_i && !rd_hi_i) |=> (st_q.lock == LK_HELD));

    // R6 and R10: a high read always leaves the lock open
    assert_lock_release_R6: assert property (@(posedge clk) disable iff (!rst_n)
        rd_hi_i |=> (st_q.lock == LK_OPEN));

    assert_hi_only_open_R8: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q.lock == LK_OPEN) && !rd_lo_i) |=> (st_q.lock == LK_OPEN));
endmodule

// File: rtl/rrl_capture.sv
module rrl_capture #(
    parameter int RES_W = 10
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [RES_W-1:0] conv_result_i,
    input  logic             conv_done_i,
    input  logic             blocked_i,
    output logic [RES_W-1:0] held_o,
    output logic             flag_set_o
);
    typedef struct packed {
        logic [RES_W-1:0] res;
        logic             flag;
    } cap_state_t;

    cap_state_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.flag = conv_done_i;
        if (conv_done_i && !blocked_i) begin
            st_d.res = conv_result_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign held_o     = st_q.res;
    assign flag_set_o = st_q.flag;

    assert_store_open_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && !blocked_i) |=> (held_o == $past(conv_result_i)));

    assert_discard_held_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_done_i && blocked_i) |=> $stable(held_o));

    assert_flag_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
        conv_done_i |=> flag_set_o);

    assert_flag_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done_i |=> !flag_set_o);

    assert_idle_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
        !conv_done_i |=> $stable(held_o));
endmodule

// File: rtl/rrl_byte_fmt.sv
module rrl_byte_fmt
    import rrl_pkg::*;
#(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic [RES_W-1:0]  held_i,
    input  logic              left_adj_i,
    output logic [BYTE_W-1:0] lo_byte_o,
    output logic [BYTE_W-1:0] hi_byte_o
);
    localparam int SPILL_W = RES_W - BYTE_W;
    localparam int PAD_W   = BYTE_W - SPILL_W;

    logic [BYTE_W-1:0] right_lo, right_hi, left_lo, left_hi;

    assign right_lo = held_i[BYTE_W-1:0];
    assign right_hi = {{PAD_W{1'b0}}, held_i[RES_W-1:BYTE_W]};
    assign left_hi  = held_i[RES_W-1 -: BYTE_W];
    assign left_lo  = {held_i[SPILL_W-1:0], {PAD_W{1'b0}}};

    always_comb begin
        if (adj_e'(left_adj_i) == ADJ_LEFT) begin
            lo_byte_o = left_lo;
            hi_byte_o = left_hi;
        end else begin
            lo_byte_o = right_lo;
            hi_byte_o = right_hi;
        end
    end
endmodule

// File: rtl/result_readout_lock.sv
module result_readout_lock #(
    parameter int RES_W  = 10,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [RES_W-1:0]  conv_result_i,
    input  logic              conv_done_i,
    input  logic              left_adj_i,
    input  logic              rd_lo_i,
    input  logic              rd_hi_i,
    output logic [BYTE_W-1:0] lo_byte_o,
    output logic [BYTE_W-1:0] hi_byte_o,
    output logic              flag_set_o
);
    logic             blocked;
    logic [RES_W-1:0] held;

    rrl_lock_ctl u_lock (
        .clk       (clk),
        .rst_n     (rst_n),
        .rd_lo_i   (rd_lo_i),
        .rd_hi_i   (rd_hi_i),
        .blocked_o (blocked)
    );

    rrl_capture #(.RES_W(RES_W)) u_cap (
        .clk           (clk),
        .rst_n         (rst_n),
        .conv_result_i (conv_result_i),
        .conv_done_i   (conv_done_i),
        .blocked_i     (blocked),
        .held_o        (held),
        .flag_set_o    (flag_set_o)
    );

    rrl_byte_fmt #(.RES_W(RES_W), .BYTE_W(BYTE_W)) u_fmt (
        .held_i     (held),
        .left_adj_i (left_adj_i),
        .lo_byte_o  (lo_byte_o),
        .hi_byte_o  (hi_byte_o)
    );

    // R1: the bytes come out of reset at zero
    assert_reset_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (lo_byte_o == '0 && hi_byte_o == '0));
endmodule

// File: tb/result_readout_lock_tb.sv
module result_readout_lock_tb_top;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [9:0] conv_result = '0;
    logic       conv_done = 1'b0;
    logic       left_adj = 1'b0;
    logic       rd_lo = 1'b0;
    logic       rd_hi = 1'b0;
    logic [7:0] lo_byte, hi_byte;
    logic       flag_set;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    result_readout_lock dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .conv_result_i (conv_result),
        .conv_done_i   (conv_done),
        .left_adj_i    (left_adj),
        .rd_lo_i       (rd_lo),
        .rd_hi_i       (rd_hi),
        .lo_byte_o     (lo_byte),
        .hi_byte_o     (hi_byte),
        .flag_set_o    (flag_set)
    );

    typedef struct packed {
        logic [9:0] res;
        logic       adj;
        logic [7:0] hi;
        logic [7:0] lo;
    } vec_t;

    localparam vec_t VECS [8] = '{
        '{10'h3FF, 1'b0, 8'h03, 8'hFF},
        '{10'h3FF, 1'b1, 8'hFF, 8'hC0},
        '{10'h000, 1'b0, 8'h00, 8'h00},
        '{10'h2A5, 1'b0, 8'h02, 8'hA5},
        '{10'h2A5, 1'b1, 8'hA9, 8'h40},
        '{10'h15A, 1'b0, 8'h01, 8'h5A},
        '{10'h15A, 1'b1, 8'h56, 8'h80},
        '{10'h201, 1'b1, 8'h80, 8'h40}
    };

    task automatic check(input string tag, input logic [15:0] act, input logic [15:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic check_bytes(input string tag, input logic [7:0] eh, input logic [7:0] el);
        check(tag, {hi_byte, lo_byte}, {eh, el});
    endtask

    // Drive one cycle of strobes; return just after the edge with strobes cleared
    task automatic cyc(input logic d, input logic [9:0] r, input logic lo, input logic hi);
        @(negedge clk);
        conv_done   = d;
        conv_result = r;
        rd_lo       = lo;
        rd_hi       = hi;
        @(posedge clk);
        #1;
        conv_done = 1'b0;
        rd_lo     = 1'b0;
        rd_hi     = 1'b0;
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_bytes("R1 reset bytes", 8'h00, 8'h00);
        check("R1 reset flag", {15'b0, flag_set}, 16'h0);
        rst_n = 1'b1;

        // Table walk; the first entry also shows the lock is released after reset (R1)
        for (int i = 0; i < 8; i++) begin
            @(negedge clk);
            left_adj = VECS[i].adj;
            cyc(1'b1, VECS[i].res, 1'b0, 1'b0);
            check_bytes(VECS[i].adj ? "R3 R4 R1 left vector" : "R2 R4 R1 right vector",
                        VECS[i].hi, VECS[i].lo);
            check("R7 flag after done", {15'b0, flag_set}, 16'h1);
        end
        cyc(1'b0, 10'h0, 1'b0, 1'b0);
        check("R7 flag drops", {15'b0, flag_set}, 16'h0);

        // Lock engage, discard and release
        @(negedge clk);
        left_adj = 1'b0;
        cyc(1'b1, 10'h2A5, 1'b0, 1'b0);
        cyc(1'b0, 10'h0, 1'b1, 1'b0);
        cyc(1'b1, 10'h15A, 1'b0, 1'b0);
        check_bytes("R5 discard while locked", 8'h02, 8'hA5);
        check("R7 flag on lost result", {15'b0, flag_set}, 16'h1);
        cyc(1'b0, 10'h0, 1'b0, 1'b1);
        check_bytes("R6 release keeps data", 8'h02, 8'hA5);
        cyc(1'b1, 10'h15A, 1'b0, 1'b0);
        check_bytes("R6 update after release", 8'h01, 8'h5A);

        // High-only read in left mode does not lock
        @(negedge clk);
        left_adj = 1'b1;
        cyc(1'b0, 10'h0, 1'b0, 1'b1);
        cyc(1'b1, 10'h3FF, 1'b0, 1'b0);
        check_bytes("R8 high-only read no lock", 8'hFF, 8'hC0);

        // Immediate reformat, no clock edge
        @(negedge clk);
        left_adj = 1'b0;
        #1;
        check_bytes("R9 reformat to right", 8'h03, 8'hFF);
        left_adj = 1'b1;
        #1;
        check_bytes("R9 reformat to left", 8'hFF, 8'hC0);
        left_adj = 1'b0;

        // Same-cycle cases
        cyc(1'b1, 10'h000, 1'b1, 1'b0);
        check_bytes("R10 done with low read discarded", 8'h03, 8'hFF);
        cyc(1'b0, 10'h0, 1'b0, 1'b1);
        cyc(1'b0, 10'h0, 1'b1, 1'b1);
        cyc(1'b1, 10'h2A5, 1'b0, 1'b0);
        check_bytes("R10 both reads leave lock open", 8'h02, 8'hA5);

        cyc(1'b0, 10'h0, 1'b1, 1'b0);
        cyc(1'b1, 10'h15A, 1'b0, 1'b1);
        check_bytes("R11 done with releasing read discarded", 8'h02, 8'hA5);
        cyc(1'b1, 10'h15A, 1'b0, 1'b0);
        check_bytes("R11 next done stored", 8'h01, 8'h5A);

        finished = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end
endmodule